// File: doc/BRIEF.md
# Inverted page table translator

The block turns a virtual address into a physical address through a single system-wide table that has one slot per physical frame. Each slot records which process owns the frame, which virtual page of that process lives there, and whether the slot is in use. Because the table is organised by frame and not by virtual page, a lookup cannot index it directly. The block instead scans it for the slot whose owner and page both match the request. The position of that slot is the frame number.

A lookup carries a process ID and a virtual address and is accepted through a valid/ready handshake, one at a time. The scan starts at slot 0 and examines one slot per clock. It stops at the first live match and returns the frame number joined to the untouched 12-bit page offset. If every slot is examined without a match, it returns a fault. Software fills or clears slots through a write port, which is honoured only while no scan is running.

Top module: `ipt_translator`

## Requirements
- R1: After reset `req_ready_o` is 1, `rsp_valid_o` is 0 and every slot is empty, so any lookup made before a write faults.
- R2: A lookup is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 from the next cycle until the cycle in which `rsp_valid_o` is 1.
- R3: The scan examines slot k in the k-th cycle after acceptance, counting from slot 0. A hit in slot k raises `rsp_valid_o` k+1 clock edges after the accepting edge.
- R4: A slot matches only when its valid flag is 1, its stored process ID equals `req_pid_i`, and its stored page equals `req_va_i[VA_W-1:12]`. A mismatch in either field, or a cleared valid flag, is not a match.
- R5: When several live slots match, the lowest-numbered one is returned.
- R6: On a hit `rsp_fault_o` is 0 and `rsp_pa_o` equals the slot number shifted left by 12, with the low 12 bits of the request address added: `{slot, va[11:0]}`.
- R7: When no slot matches, `rsp_fault_o` is 1 and `rsp_pa_o` is 0. The response comes N_FRAMES clock edges after the accepting edge.
- R8: `rsp_valid_o` is high for exactly one cycle per accepted lookup.
- R9: A write with `wr_en_i` = 1 while `req_ready_o` = 1 sets slot `wr_idx_i` to the given process ID, page and valid flag. A valid flag of 0 empties the slot.
- R10: A write presented while `req_ready_o` = 0 is ignored and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Lookup request present |
| req_ready_o | output | 1 | Block idle, able to accept a lookup or a write |
| req_pid_i | input | PID_W | Requesting process ID |
| req_va_i | input | VA_W | Virtual address to translate |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_fault_o | output | 1 | Page fault: no live matching slot |
| rsp_pa_o | output | $clog2(N_FRAMES)+12 | Physical address, 0 on fault |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | $clog2(N_FRAMES) | Slot to write |
| wr_pid_i | input | PID_W | Owner process ID to store |
| wr_vpn_i | input | VA_W-12 | Virtual page number to store |
| wr_valid_i | input | 1 | Valid flag to store |

## Verification
Lookups are tried against slots 0, 6, 9, 40 and 63. Checking the response cycle for each shows that the scan advances one slot per cycle from the bottom, and slot 63 with an all-ones address also exposes any truncation in frame or offset. Requests that share a page with a stored slot but carry a different process ID, and slots written with the valid flag cleared, show that all three match conditions are needed. A duplicated mapping that is then cleared separates first-match priority from last-match. A write issued in the middle of a scan, followed by a repeat lookup, shows whether the table is guarded while busy.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;

  localparam int unsigned OFFS_W = 12;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int unsigned N_FRAMES = 64,
  parameter int unsigned PID_W    = 8,
  parameter int unsigned VPN_W    = 20,
  localparam int unsigned IDX_W   = ipt_pkg::idx_width(N_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_allow_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic             wr_valid_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [PID_W-1:0] rd_pid_o,
  output logic [VPN_W-1:0] rd_vpn_o
);
  logic [N_FRAMES-1:0]            slot_valid_q;
  logic [N_FRAMES-1:0][PID_W-1:0] slot_pid_q;
  logic [N_FRAMES-1:0][VPN_W-1:0] slot_vpn_q;
  logic                           wr_take;

  assign wr_take = wr_en_i && wr_allow_i;

  for (genvar g = 0; g < N_FRAMES; g++) begin : g_slot
    logic sel;
    assign sel = wr_take && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_valid_q[g] <= 1'b0;
        slot_pid_q[g]   <= '0;
        slot_vpn_q[g]   <= '0;
      end else if (sel) begin
        slot_valid_q[g] <= wr_valid_i;
        slot_pid_q[g]   <= wr_pid_i;
        slot_vpn_q[g]   <= wr_vpn_i;
      end
    end
  end

  always_comb begin
    rd_valid_o = 1'b0;
    rd_pid_o   = '0;
    rd_vpn_o   = '0;
    if (32'(rd_idx_i) < N_FRAMES) begin
      rd_valid_o = slot_valid_q[rd_idx_i];
      rd_pid_o   = slot_pid_q[rd_idx_i];
      rd_vpn_o   = slot_vpn_q[rd_idx_i];
    end
  end

  assert_busy_write_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_allow_i) |=> ($stable(slot_valid_q) && $stable(slot_pid_q) && $stable(slot_vpn_q)));

  assert_write_lands_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_take |=> (slot_valid_q[$past(wr_idx_i)] == $past(wr_valid_i)) &&
                (slot_vpn_q[$past(wr_idx_i)] == $past(wr_vpn_i)));
endmodule

// File: rtl/ipt_scan.sv
module ipt_scan #(
  parameter int unsigned N_FRAMES = 64,
  parameter int unsigned PID_W    = 8,
  parameter int unsigned VA_W     = 32,
  localparam int unsigned OFFS_W  = ipt_pkg::OFFS_W,
  localparam int unsigned VPN_W   = VA_W - OFFS_W,
  localparam int unsigned IDX_W   = ipt_pkg::idx_width(N_FRAMES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [PID_W-1:0]  req_pid_i,
  input  logic [VA_W-1:0]   req_va_i,
  output logic              req_ready_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic              rd_valid_i,
  input  logic [PID_W-1:0]  rd_pid_i,
  input  logic [VPN_W-1:0]  rd_vpn_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [OFFS_W-1:0] offs_o
);
  import ipt_pkg::*;

  scan_state_e       st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PID_W-1:0]  pid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFFS_W-1:0] offs_q;
  logic              match;
  logic              last;
  logic              accept;

  assign accept   = (st_q == ST_IDLE) && req_valid_i;
  assign match    = (st_q == ST_SCAN) && rd_valid_i &&
                    (rd_pid_i == pid_q) && (rd_vpn_i == vpn_q);
  assign last     = (idx_q == IDX_W'(N_FRAMES - 1));

  assign req_ready_o = (st_q == ST_IDLE);
  assign rd_idx_o    = idx_q;
  assign hit_o       = match;
  assign miss_o      = (st_q == ST_SCAN) && !match && last;
  assign hit_idx_o   = idx_q;
  assign offs_o      = offs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      pid_q  <= '0;
      vpn_q  <= '0;
      offs_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q   <= ST_SCAN;
            idx_q  <= '0;
            pid_q  <= req_pid_i;
            vpn_q  <= req_va_i[VA_W-1:OFFS_W];
            offs_q <= req_va_i[OFFS_W-1:0];
          end
        end
        ST_SCAN: begin
          if (match || last) st_q <= ST_IDLE;
          else               idx_q <= idx_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (!req_ready_o && idx_q == '0));

  assert_scan_steps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SCAN && !match && !last) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/ipt_rsp.sv
module ipt_rsp #(
  parameter int unsigned N_FRAMES = 64,
  localparam int unsigned OFFS_W  = ipt_pkg::OFFS_W,
  localparam int unsigned IDX_W   = ipt_pkg::idx_width(N_FRAMES),
  localparam int unsigned PA_W    = IDX_W + OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              miss_i,
  input  logic [IDX_W-1:0]  hit_idx_i,
  input  logic [OFFS_W-1:0] offs_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [PA_W-1:0]   rsp_pa_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_pa_o    <= '0;
    end else begin
      rsp_valid_o <= hit_i || miss_i;
      if (hit_i) begin
        rsp_fault_o <= 1'b0;
        rsp_pa_o    <= {hit_idx_i, offs_i};
      end else if (miss_i) begin
        rsp_fault_o <= 1'b1;
        rsp_pa_o    <= '0;
      end
    end
  end

  assert_hit_miss_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_i && miss_i));

  assert_rsp_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: rtl/ipt_translator.sv
module ipt_translator #(
  parameter int unsigned N_FRAMES = 64,
  parameter int unsigned PID_W    = 8,
  parameter int unsigned VA_W     = 32,
  localparam int unsigned OFFS_W  = ipt_pkg::OFFS_W,
  localparam int unsigned VPN_W   = VA_W - OFFS_W,
  localparam int unsigned IDX_W   = ipt_pkg::idx_width(N_FRAMES),
  localparam int unsigned PA_W    = IDX_W + OFFS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [PID_W-1:0] req_pid_i,
  input  logic [VA_W-1:0]  req_va_i,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic             wr_valid_i
);
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_valid;
  logic [PID_W-1:0]  rd_pid;
  logic [VPN_W-1:0]  rd_vpn;
  logic              hit;
  logic              miss;
  logic [IDX_W-1:0]  hit_idx;
  logic [OFFS_W-1:0] offs;

  ipt_table #(.N_FRAMES(N_FRAMES), .PID_W(PID_W), .VPN_W(VPN_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_allow_i (req_ready_o),
    .wr_idx_i   (wr_idx_i),
    .wr_pid_i   (wr_pid_i),
    .wr_vpn_i   (wr_vpn_i),
    .wr_valid_i (wr_valid_i),
    .rd_idx_i   (rd_idx),
    .rd_valid_o (rd_valid),
    .rd_pid_o   (rd_pid),
    .rd_vpn_o   (rd_vpn)
  );

  ipt_scan #(.N_FRAMES(N_FRAMES), .PID_W(PID_W), .VA_W(VA_W)) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_pid_i   (req_pid_i),
    .req_va_i    (req_va_i),
    .req_ready_o (req_ready_o),
    .rd_idx_o    (rd_idx),
    .rd_valid_i  (rd_valid),
    .rd_pid_i    (rd_pid),
    .rd_vpn_i    (rd_vpn),
    .hit_o       (hit),
    .miss_o      (miss),
    .hit_idx_o   (hit_idx),
    .offs_o      (offs)
  );

  ipt_rsp #(.N_FRAMES(N_FRAMES)) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .miss_i      (miss),
    .hit_idx_i   (hit_idx),
    .offs_i      (offs),
    .rsp_valid_o (rsp_valid_o),
    .rsp_fault_o (rsp_fault_o),
    .rsp_pa_o    (rsp_pa_o)
  );

  assert_idle_at_rsp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);

  assert_fault_zero_pa_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_pa_o == '0));
endmodule

// File: tb/ipt_translator_test.sv
`timescale 1ns/1ps
module ipt_translator_test;
  localparam int N  = 64;
  localparam int PW = 8;
  localparam int VW = 32;
  localparam int IW = $clog2(N);
  localparam int AW = IW + 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [PW-1:0] req_pid = '0;
  logic [VW-1:0] req_va = '0;
  logic          rsp_valid, rsp_fault;
  logic [AW-1:0] rsp_pa;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [PW-1:0] wr_pid = '0;
  logic [VW-13:0] wr_vpn = '0;
  logic          wr_valid = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ipt_translator #(.N_FRAMES(N), .PID_W(PW), .VA_W(VW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_pid_i(req_pid), .req_va_i(req_va),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_pa_o(rsp_pa),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_pid_i(wr_pid),
    .wr_vpn_i(wr_vpn), .wr_valid_i(wr_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input int idx, input int pid, input int vpn, input bit v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_pid = PW'(pid); wr_vpn = (VW-12)'(vpn); wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Issue one lookup; optionally issue a write on the 3rd cycle of the scan.
  task automatic lookup(input int pid, input longint va, input bit mid_wr,
                        output bit flt, output longint pa, output int lat,
                        output bit busy_ok, output bit pulse_ok);
    @(negedge clk);
    req_valid = 1'b1; req_pid = PW'(pid); req_va = VW'(va);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = !req_ready;
    lat = 0;
    flt = 1'b0; pa = 0; pulse_ok = 1'b0;
    while (lat < 300) begin
      if (mid_wr && lat == 3) begin
        wr_en = 1'b1; wr_idx = '0; wr_pid = PW'(3); wr_vpn = (VW-12)'(3); wr_valid = 1'b1;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      wr_en = 1'b0;
      if (rsp_valid) break;
      if (req_ready) busy_ok = 1'b0;
    end
    flt = rsp_fault;
    pa = longint'(rsp_pa);
    @(posedge clk);
    @(negedge clk);
    pulse_ok = !rsp_valid;
  endtask

  task automatic expect_hit(input string req, input int pid, input longint va,
                            input int frame, input bit mid_wr);
    bit f, b, p; longint pa; int lat; longint exp_pa;
    exp_pa = (longint'(frame) << 12) + (va & 64'hFFF);
    lookup(pid, va, mid_wr, f, pa, lat, b, p);
    check(f == 1'b0, req, "fault on hit", f, 0);
    check(pa == exp_pa, req, "physical address", pa, exp_pa);
    check(lat == frame + 1, req, "hit latency", lat, frame + 1);
    check(b, req, "ready low during scan R2", b, 1);
    check(p, req, "single-cycle strobe R8", p, 1);
  endtask

  task automatic expect_fault(input string req, input int pid, input longint va);
    bit f, b, p; longint pa; int lat;
    lookup(pid, va, 1'b0, f, pa, lat, b, p);
    check(f == 1'b1, req, "fault flag", f, 1);
    check(pa == 0, req, "pa on fault R7", pa, 0);
    check(lat == N, req, "fault latency R7", lat, N);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    expect_fault("R1", 0, 0);
  endtask

  task automatic t_basic();
    put(9, 3, 1, 1'b1);                   // R9
    expect_hit("R6", 3, 7000, 9, 1'b0);   // 39768, R3 latency 10
    put(6, 3, 3, 1'b1);
    expect_hit("R3", 3, 13452, 6, 1'b0);  // 25740
  endtask

  task automatic t_match_fields();
    expect_fault("R4", 4, 7000);          // pid differs
    expect_fault("R4", 3, 2 * 4096 + 5);  // vpn differs
    put(2, 5, 7, 1'b0);                   // stored invalid
    expect_fault("R4", 5, 7 * 4096);
  endtask

  task automatic t_first_match();
    put(40, 3, 1, 1'b1);
    expect_hit("R5", 3, 7000, 9, 1'b0);
    put(9, 3, 1, 1'b0);                   // R9 clear
    expect_hit("R9", 3, 7000, 40, 1'b0);
  endtask

  task automatic t_busy_write();
    expect_hit("R10", 3, 13452, 6, 1'b1); // write to slot 0 mid-scan
    expect_hit("R10", 3, 13452, 6, 1'b0); // slot 0 still empty
  endtask

  task automatic t_edges();
    put(63, 8'hFF, 20'hFFFFF, 1'b1);
    expect_hit("R3", 8'hFF, 64'hFFFF_FFFF, 63, 1'b0);
    put(0, 1, 0, 1'b1);
    expect_hit("R6", 1, 64'h0000_0ABC, 0, 1'b0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_match_fields();
    t_first_match();
    t_busy_write();
    t_edges();
    report();
  end
endmodule